// File: doc/BRIEF.md
# Hot-Swap Gate Enable Sequencer

This block is the digital sequencer of a hot-swap controller for a negative-rail pass transistor. It takes comparator flags that are already digitized: supply above lockout, undervoltage pin high, overvoltage pin high, sense over limit, drain below threshold and gate near its final level. It also takes a breaker-trip pulse from a separate fault integrator and a slow timebase tick. From these it decides whether the gate pull-up runs, whether the strong pull-down holds the gate low, and whether a regulating pull-down is requested. It also keeps a latched power-good flag.

The gate turns on only when the supply is inside its window and the sense voltage is below the limit. The gate drops at once when the window is lost. A breaker trip latches the block off. Software or a supervisor clears the latch by taking the undervoltage input low, or by a loss of supply. However, the gate stays held low until a latch-off count of timebase ticks, started at the fault, has run out. A parameter selects the polarity of the power-good output.

Top module: `hs_gate_seq`

## Requirements
- R1: Out of reset, the block holds the gate off: gate_up_o=0, gate_pd_o=1, gate_reg_o=0, and power-good is deasserted.
- R2: From the off state, the gate pull-up turns on one clock edge after all four of these hold together: supply_ok_i=1, uv_hi_i=1, ov_hi_i=0 and sense_over_i=0. Any other combination leaves the gate off.
- R3: While the gate is on, uv_hi_i=0, ov_hi_i=1 or supply_ok_i=0 drops gate_up_o and raises gate_pd_o in the same cycle, with no clock edge. The gate stays off until the R2 conditions hold again.
- R4: A trip_i pulse while the gate is on latches a fault on the next edge: gate_pd_o=1 and gate_up_o=0, even after the supply window returns. A trip_i while the gate is off is ignored.
- R5: The fault latch is released by uv_hi_i=0 or supply_ok_i=0 while the fault is latched. A release level in the same cycle as the trip does not count.
- R6: After a fault, the gate stays held low until OFF_TICKS tick_i pulses have been counted from the fault. This holds even when the release came earlier. Once both the count and the release are done, the block returns to off and restarts under R2.
- R7: Power-good is set on the edge after gate-on, drain_low_i=1 and gate_near_i=1 hold together. It then stays set while the gate remains on, even when those flags drop.
- R8: Power-good clears on the edge after the gate is off for any reason: undervoltage, overvoltage, lockout or fault.
- R9: With PG_ACTIVE_LOW=0, pgood_o is 1 when power is good. With PG_ACTIVE_LOW=1, pgood_o is 0 when power is good.
- R10: While the gate is on, sense_over_i=1 clears gate_up_o and sets gate_reg_o in the same cycle, keeps gate_pd_o=0 and latches no fault. The pull-up returns once sense_over_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply above internal lockout |
| uv_hi_i | input | 1 | Undervoltage comparator high (supply adequate) |
| ov_hi_i | input | 1 | Overvoltage comparator high (supply excessive) |
| sense_over_i | input | 1 | Sense voltage at or over current limit |
| drain_low_i | input | 1 | Drain below power-good threshold |
| gate_near_i | input | 1 | Gate near its final drive level |
| trip_i | input | 1 | Breaker-trip pulse from fault integrator |
| tick_i | input | 1 | Latch-off timebase tick |
| gate_up_o | output | 1 | Gate pull-up enable |
| gate_pd_o | output | 1 | Strong gate pull-down |
| gate_reg_o | output | 1 | Regulating pull-down request |
| pgood_o | output | 1 | Latched power-good, polarity per PG_ACTIVE_LOW |

## Verification
Two events can land on the same edge. The first case is a breaker trip arriving in the same cycle as the undervoltage drop. The bench drives both together and expects the fault to win. Because that undervoltage level came before the latch existed, it must not count as a release. The bench judges this by running the full latch-off count and confirming that the gate still stays low until a later undervoltage pulse.

The second case is a release that lands before the count ends, compared with one that lands after it. The bench expects the restart only once both have happened.

The gate-enable conditions are swept over all sixteen combinations of the four start flags. The power-good latch is exercised under every pair of drain and gate flags. Both output polarities are checked side by side.

// File: rtl/hs_gate_seq_pkg.sv
package hs_gate_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_FAULT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hs_latchoff_timer.sv
module hs_latchoff_timer #(
  parameter int unsigned OFF_TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(OFF_TICKS + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(OFF_TICKS);

  logic [CNT_W-1:0] cnt_q;

  // count restarts from zero whenever the fault latch is not held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!run_i)                     cnt_q <= '0;
    else if (tick_i && (cnt_q != TERM))  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == TERM);

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM);

  // R6
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_gate_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic uv_hi_i,
  input  logic ov_hi_i,
  input  logic sense_over_i,
  input  logic trip_i,
  input  logic timer_done_i,
  output logic fault_o,
  output logic gate_on_o,
  output logic gate_up_o,
  output logic gate_pd_o,
  output logic gate_reg_o
);
  seq_state_e state_q, state_d;
  logic       rel_q;
  logic       window_ok, release_now;

  assign window_ok   = supply_ok_i & uv_hi_i & ~ov_hi_i;
  assign release_now = ~uv_hi_i | ~supply_ok_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (window_ok && !sense_over_i) state_d = ST_ON;
      ST_ON: begin
        if (trip_i)          state_d = ST_FAULT;
        else if (!window_ok) state_d = ST_OFF;
      end
      ST_FAULT: if (timer_done_i && (rel_q || release_now)) state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      // release only counts once the latch already exists
      if (state_q != ST_FAULT) rel_q <= 1'b0;
      else if (release_now)    rel_q <= 1'b1;
    end
  end

  // shutdown path is combinational: no edge between window loss and gate off
  assign gate_on_o  = (state_q == ST_ON) & window_ok;
  assign gate_up_o  = gate_on_o & ~sense_over_i;
  assign gate_reg_o = gate_on_o & sense_over_i;
  assign gate_pd_o  = ~gate_on_o;
  assign fault_o    = (state_q == ST_FAULT);

  // R2
  start_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |=> ((state_q != ST_ON) || $past(window_ok && !sense_over_i)));

  // R4
  trip_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && trip_i) |=> (state_q == ST_FAULT));

  // R6
  latchoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT && !timer_done_i) |=> (state_q == ST_FAULT));

  // R3
  gate_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !window_ok |-> (!gate_up_o && !gate_reg_o));
endmodule

// File: rtl/hs_pgood_latch.sv
module hs_pgood_latch #(
  parameter bit PG_ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_on_i,
  input  logic drain_low_i,
  input  logic gate_near_i,
  output logic pgood_o
);
  logic pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= 1'b0;
    else         pg_q <= gate_on_i & (pg_q | (drain_low_i & gate_near_i));
  end

  generate
    if (PG_ACTIVE_LOW) begin : g_pol_low
      assign pgood_o = ~pg_q;
    end else begin : g_pol_high
      assign pgood_o = pg_q;
    end
  endgenerate

  // R7
  pg_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_q) |-> $past(gate_on_i && drain_low_i && gate_near_i));

  // R8
  pg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_on_i |=> !pg_q);
endmodule

// File: rtl/hs_gate_seq.sv
module hs_gate_seq #(
  parameter int unsigned OFF_TICKS     = 64,
  parameter bit          PG_ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic uv_hi_i,
  input  logic ov_hi_i,
  input  logic sense_over_i,
  input  logic drain_low_i,
  input  logic gate_near_i,
  input  logic trip_i,
  input  logic tick_i,
  output logic gate_up_o,
  output logic gate_pd_o,
  output logic gate_reg_o,
  output logic pgood_o
);
  logic fault, gate_on, timer_done;

  hs_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_ok_i  (supply_ok_i),
    .uv_hi_i      (uv_hi_i),
    .ov_hi_i      (ov_hi_i),
    .sense_over_i (sense_over_i),
    .trip_i       (trip_i),
    .timer_done_i (timer_done),
    .fault_o      (fault),
    .gate_on_o    (gate_on),
    .gate_up_o    (gate_up_o),
    .gate_pd_o    (gate_pd_o),
    .gate_reg_o   (gate_reg_o)
  );

  hs_latchoff_timer #(.OFF_TICKS(OFF_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (fault),
    .tick_i (tick_i),
    .done_o (timer_done)
  );

  hs_pgood_latch #(.PG_ACTIVE_LOW(PG_ACTIVE_LOW)) u_pg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gate_on_i   (gate_on),
    .drain_low_i (drain_low_i),
    .gate_near_i (gate_near_i),
    .pgood_o     (pgood_o)
  );

  // R4
  fault_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |-> (gate_pd_o && !gate_up_o && !gate_reg_o));
endmodule

// File: tb/hs_gate_seq_bench.sv
module hs_gate_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 0, uv = 0, ov = 0, sen = 0, drn = 0, gnr = 0, trip = 0, tick = 0;
  logic up, pd, rg, pg, up_n, pd_n, rg_n, pg_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_gate_seq #(.OFF_TICKS(TICKS), .PG_ACTIVE_LOW(1'b0)) u_hs_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .uv_hi_i(uv), .ov_hi_i(ov),
    .sense_over_i(sen), .drain_low_i(drn), .gate_near_i(gnr), .trip_i(trip),
    .tick_i(tick), .gate_up_o(up), .gate_pd_o(pd), .gate_reg_o(rg), .pgood_o(pg));

  hs_gate_seq #(.OFF_TICKS(TICKS), .PG_ACTIVE_LOW(1'b1)) u_hs_gate_seq_n (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .uv_hi_i(uv), .ov_hi_i(ov),
    .sense_over_i(sen), .drain_low_i(drn), .gate_near_i(gnr), .trip_i(trip),
    .tick_i(tick), .gate_up_o(up_n), .gate_pd_o(pd_n), .gate_reg_o(rg_n), .pgood_o(pg_n));

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: up/pd/reg act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_gate(string req, logic eu, logic ep, logic er);
    #1;
    chk(req, {up, pd, rg}, {eu, ep, er});
    chk(req, {up_n, pd_n, rg_n}, {eu, ep, er});
  endtask

  task automatic chk_pg(string req, logic exp);
    #1;
    n_chk++;
    if (pg !== exp || pg_n !== ~exp) begin
      n_fail++;
      $display("FAIL %s: pgood act=%b/%b exp=%b/%b", req, pg, pg_n, exp, ~exp);
    end
  endtask

  task automatic go_on();
    sup = 1; uv = 1; ov = 0; sen = 0; trip = 0;
    cyc();
  endtask

  task automatic go_off();
    uv = 0;
    cyc();
    uv = 1;
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(); tick = 0; cyc();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk_gate("R1", 0, 1, 0);
    chk_pg("R1", 0);
    rst_n = 1;
    cyc();
    chk_gate("R1", 0, 1, 0);

    // R2 sweep all start-flag combinations from off
    for (int v = 0; v < 16; v++) begin
      sup = v[0]; uv = v[1]; ov = v[2]; sen = v[3];
      cyc();
      chk_gate("R2", (v == 3), (v != 3), 0);
      sup = 1; uv = 0; ov = 0; sen = 0;
      cyc(2);
    end

    // R3 immediate shutdown for each cause, then hold and restart
    for (int c = 0; c < 3; c++) begin
      go_on();
      chk_gate("R3", 1, 0, 0);
      if (c == 0) uv = 0; else if (c == 1) ov = 1; else sup = 0;
      chk_gate("R3", 0, 1, 0);
      cyc(3);
      chk_gate("R3", 0, 1, 0);
      uv = 1; ov = 0; sup = 1;
      cyc();
      chk_gate("R3", 1, 0, 0);
      go_off();
    end

    // R7/R8/R9 power-good sweep over drain/gate flags
    for (int v = 0; v < 4; v++) begin
      go_on();
      drn = v[0]; gnr = v[1];
      cyc();
      chk_pg("R7", (v == 3));
      drn = 0; gnr = 0;
      cyc();
      chk_pg("R7", (v == 3));
      // R10 regulation keeps power-good, no fault
      sen = 1;
      chk_gate("R10", 0, 0, 1);
      cyc(5);
      chk_gate("R10", 0, 0, 1);
      chk_pg("R10", (v == 3));
      sen = 0;
      chk_gate("R10", 1, 0, 0);
      ov = 1;
      cyc();
      chk_pg("R8", 0);
      ov = 0;
      cyc();
      chk_pg("R8", 0);
      go_off();
    end

    // R4 trip while off ignored
    uv = 0; trip = 1; cyc(); trip = 0; uv = 1;
    cyc();
    chk_gate("R4", 1, 0, 0);

    // R4/R5/R6 trip, early release, latch-off count
    drn = 1; gnr = 1; cyc();
    chk_pg("R7", 1);
    trip = 1; cyc(); trip = 0;
    chk_gate("R4", 0, 1, 0);
    cyc();
    chk_pg("R8", 0);
    uv = 0; cyc(); uv = 1; cyc();
    chk_gate("R6", 0, 1, 0);
    pulse_ticks(TICKS - 1);
    cyc(5);
    chk_gate("R6", 0, 1, 0);
    tick = 1; cyc(); tick = 0;
    chk_gate("R6", 0, 1, 0);
    cyc(2);
    chk_gate("R6", 1, 0, 0);
    drn = 0; gnr = 0;
    go_off();

    // R5 count done but no release: stays latched
    go_on();
    trip = 1; cyc(); trip = 0;
    pulse_ticks(TICKS + 2);
    cyc(3);
    chk_gate("R5", 0, 1, 0);
    sup = 0; cyc(); sup = 1;
    cyc(2);
    chk_gate("R5", 1, 0, 0);
    go_off();

    // R5 release coincident with trip does not count
    go_on();
    trip = 1; uv = 0; cyc(); trip = 0; uv = 1;
    pulse_ticks(TICKS + 1);
    cyc(3);
    chk_gate("R5", 0, 1, 0);
    uv = 0; cyc(); uv = 1; cyc(2);
    chk_gate("R5", 1, 0, 0);

    // R1 reset mid-operation
    drn = 1; gnr = 1; cyc();
    rst_n = 0; #1;
    chk_gate("R1", 0, 1, 0);
    chk_pg("R1", 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule